// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block produces interrupts for one GPIO port of eight pins and merges them into a single shared request. Each pin has its own enable bit and a two-bit trigger selection. The selection picks a rising edge, a falling edge, or any difference from the value captured at the last read of the port. A small register interface lets software program the per-pin configuration, read the port and the per-pin interrupt lines, and clear the sticky edge flags.

All per-pin interrupt lines are ORed together. A rising edge of that OR sets a pending request flop. The flop is cleared by an acknowledge pulse from the interrupt priority logic. The pending request leaves the block only while both the port-level mask bit and the global interrupt enable are high. Because only a rising edge of the OR raises a request, a pin line that stays high blocks every later request until software clears all active sources.

Pin inputs pass through a two-flop synchronizer before any edge or change detection. Reset is synchronous and active high.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset, the enable register and both control registers read 0, every per-pin interrupt line reads 0, and `irq_o` is 0.
- R2: A pin whose enable bit is clear never drives its interrupt line high, whatever its trigger selection and input activity.
- R3: The trigger code of pin i is {hi bit i, lo bit i}, with the lo bits at address 1 and the hi bits at address 3. Code 00 disables the pin's interrupt line.
- R4: With code 01 (rising), a synchronized 0-to-1 transition on an enabled pin sets a sticky flag. The flag stays set after the pin returns low and drives the pin's interrupt line.
- R5: With code 10 (falling), a synchronized 1-to-0 transition sets the sticky flag. A 0-to-1 transition does not set it.
- R6: With code 11 (change), the pin's interrupt line is high while the synchronized pin differs from a reference bit. A read of address 0 (port) loads the reference bits from the synchronized pins.
- R7: Address 4 reads the eight per-pin interrupt lines. Writing 1 to a bit at address 4 clears that pin's sticky edge flag. Writing 0 to a bit leaves its flag unchanged.
- R8: The pending request is set only by a 0-to-1 transition of the OR of all per-pin lines. While any line stays high, further pin events raise no new request.
- R9: `irq_o` is high only while the request is pending, `mask_en_i` is high and `global_en_i` is high. A pending request survives while it is masked.
- R10: An `irq_ack_i` pulse clears the pending request when no new OR edge occurs in the same cycle.
- R11: The enable register (address 2) and both control registers read back the values written to them. Address 0 reads the synchronized pin values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a port read loads the change reference) |
| addr | input | 3 | Register address: 0 port, 1 trigger lo, 2 enable, 3 trigger hi, 4 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| mask_en_i | input | 1 | Port-level interrupt mask bit |
| global_en_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Acknowledge pulse from priority logic |
| irq_o | output | 1 | Gated shared interrupt request |

## Verification
The assertions check several properties on every cycle:
- no disabled or code-00 pin ever drives its line;
- `irq_o` never rises without the request pending and both gates high;
- the pending flop only rises after a rising edge of the OR;
- the pending flop holds until acknowledged;
- an acknowledge with a steady OR clears it.

The directed scenarios cover what needs sequences of stimulus:
- sticky rising and falling flags that outlive the pin pulse;
- the change reference moving on a port read;
- write-one-to-clear;
- the blocking effect of a source that stays asserted, until both flags are cleared and a fresh edge arrives.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_RISE   = 2'b01,
        MODE_FALL   = 2'b10,
        MODE_CHANGE = 2'b11
    } edge_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT   = 3'd0,
        REG_TRG_LO = 3'd1,
        REG_ENABLE = 3'd2,
        REG_TRG_HI = 3'd3,
        REG_STATUS = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic       en;
        edge_mode_e mode;
    } pin_cfg_t;

    function automatic pin_cfg_t make_cfg(logic en, logic lo, logic hi);
        pin_cfg_t c;
        c.en   = en;
        c.mode = edge_mode_e'({hi, lo});
        return c;
    endfunction

    function automatic logic is_edge_mode(edge_mode_e m);
        return (m == MODE_RISE) || (m == MODE_FALL);
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     pin_s,
    input  logic     pin_prev,
    input  logic     snap,
    input  logic     clr,
    output logic     line
);
    logic ref_q;
    logic flag_q;
    logic rise_evt, fall_evt, hit;

    assign rise_evt = pin_s & ~pin_prev;
    assign fall_evt = ~pin_s & pin_prev;
    assign hit = cfg.en & (((cfg.mode == MODE_RISE) & rise_evt) |
                           ((cfg.mode == MODE_FALL) & fall_evt));

    always_ff @(posedge clk) begin
        if (rst)       ref_q <= 1'b0;
        else if (snap) ref_q <= pin_s;
    end

    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    always_comb begin
        line = 1'b0;
        if (cfg.en) begin
            if (is_edge_mode(cfg.mode))        line = flag_q;
            else if (cfg.mode == MODE_CHANGE)  line = pin_s ^ ref_q;
        end
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_s,
    input  logic [W-1:0]      lines,
    output logic [W-1:0]      en_q,
    output logic [W-1:0]      lo_q,
    output logic [W-1:0]      hi_q,
    output logic              snap,
    output logic [W-1:0]      clr,
    output logic [W-1:0]      rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_ENABLE: en_q <= wdata;
                REG_TRG_LO: lo_q <= wdata;
                REG_TRG_HI: hi_q <= wdata;
                default: ;
            endcase
        end
    end

    assign snap = rd_en && (addr == REG_PORT);
    assign clr  = (wr_en && (addr == REG_STATUS)) ? wdata : '0;

    always_comb begin
        case (addr)
            REG_PORT:   rdata = pin_s;
            REG_ENABLE: rdata = en_q;
            REG_TRG_LO: rdata = lo_q;
            REG_TRG_HI: rdata = hi_q;
            REG_STATUS: rdata = lines;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    input  logic         ack,
    input  logic         mask_en,
    input  logic         global_en,
    output logic         any_out,
    output logic         any_q,
    output logic         pend_q,
    output logic         irq
);
    logic or_rise;

    assign any_out = |lines;
    assign or_rise = any_out & ~any_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            any_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            any_q <= any_out;
            if (or_rise)  pend_q <= 1'b1;
            else if (ack) pend_q <= 1'b0;
        end
    end

    assign irq = pend_q & mask_en & global_en;
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_irq_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int STAGES = SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      pin_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              mask_en_i,
    input  logic              global_en_i,
    input  logic              irq_ack_i,
    output logic              irq_o
);
    logic [W-1:0] pin_s, pin_prev;
    logic [W-1:0] cfg_en, cfg_lo, cfg_hi;
    logic [W-1:0] pin_out, clr;
    logic         snap, any_out, any_q, pend_q;

    gpio_irq_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_i), .q(pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) pin_prev <= '0;
        else     pin_prev <= pin_s;
    end

    gpio_irq_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .pin_s(pin_s), .lines(pin_out), .en_q(cfg_en),
        .lo_q(cfg_lo), .hi_q(cfg_hi), .snap(snap), .clr(clr), .rdata(rdata)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk(clk), .rst(rst),
            .cfg(make_cfg(cfg_en[i], cfg_lo[i], cfg_hi[i])),
            .pin_s(pin_s[i]), .pin_prev(pin_prev[i]), .snap(snap),
            .clr(clr[i]), .line(pin_out[i])
        );
    end

    gpio_irq_merge #(.W(W)) u_merge (
        .clk(clk), .rst(rst), .lines(pin_out), .ack(irq_ack_i),
        .mask_en(mask_en_i), .global_en(global_en_i), .any_out(any_out),
        .any_q(any_q), .pend_q(pend_q), .irq(irq_o)
    );
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         irq_o,
    input logic         mask_en_i,
    input logic         global_en_i,
    input logic         irq_ack_i,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] cfg_en,
    input logic [W-1:0] cfg_lo,
    input logic [W-1:0] cfg_hi,
    input logic         any_out,
    input logic         any_q,
    input logic         pend_q
);
    // R2
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~cfg_en) == '0);

    // R3
    off_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~(cfg_lo | cfg_hi)) == '0);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask_en_i && global_en_i && pend_q));

    // R8
    pend_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(any_out && !any_q));

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !irq_ack_i) |=> pend_q);

    // R10
    ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_i && $stable(any_out)) |=> !pend_q);
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .mask_en_i(mask_en_i),
    .global_en_i(global_en_i), .irq_ack_i(irq_ack_i), .pin_out(pin_out),
    .cfg_en(cfg_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .any_out(any_out),
    .any_q(any_q), .pend_q(pend_q)
);

// File: tb/gpio_port_irq_bench.sv
module gpio_port_irq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_i = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       mask_en_i = 1'b1, global_en_i = 1'b1, irq_ack_i = 1'b0;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port_irq u_gpio_port_irq (
        .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .mask_en_i(mask_en_i),
        .global_en_i(global_en_i), .irq_ack_i(irq_ack_i), .irq_o(irq_o)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic port_read(output logic [7:0] d);
        @(negedge clk);
        addr = 3'd0; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pin_i = '0; wr_en = 1'b0; rd_en = 1'b0; irq_ack_i = 1'b0;
        mask_en_i = 1'b1; global_en_i = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        peek(3'd1, v); check("R1 lo reg", v, 8'h00);
        peek(3'd2, v); check("R1 enable reg", v, 8'h00);
        peek(3'd3, v); check("R1 hi reg", v, 8'h00);
        peek(3'd4, v); check("R1 status", v, 8'h00);
        check("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        do_reset();
        bus_write(3'd2, 8'hA5); bus_write(3'd1, 8'h3C); bus_write(3'd3, 8'h81);
        peek(3'd2, v); check("R11 enable readback", v, 8'hA5);
        peek(3'd1, v); check("R11 lo readback", v, 8'h3C);
        peek(3'd3, v); check("R11 hi readback", v, 8'h81);
        pin_i = 8'h5A; wait_n(3);
        port_read(v); check("R11 port read", v, 8'h5A);
    endtask

    task automatic t_rise();
        logic [7:0] v;
        do_reset();
        bus_write(3'd2, 8'h01); bus_write(3'd1, 8'h01);
        pin_i[0] = 1'b1; wait_n(6);
        peek(3'd4, v); check("R4 rise flag", v, 8'h01);
        check("R4 irq", {7'd0, irq_o}, 8'h01);
        pin_i[0] = 1'b0; wait_n(6);
        peek(3'd4, v); check("R4 flag sticky", v, 8'h01);
        bus_write(3'd4, 8'h00); wait_n(1);
        peek(3'd4, v); check("R7 write 0 keeps flag", v, 8'h01);
        bus_write(3'd4, 8'h01); wait_n(1);
        peek(3'd4, v); check("R7 w1c clears flag", v, 8'h00);
    endtask

    task automatic t_fall();
        logic [7:0] v;
        do_reset();
        bus_write(3'd2, 8'h20); bus_write(3'd3, 8'h20);
        pin_i[5] = 1'b1; wait_n(6);
        peek(3'd4, v); check("R5 rise ignored", v, 8'h00);
        check("R5 no irq on rise", {7'd0, irq_o}, 8'h00);
        pin_i[5] = 1'b0; wait_n(6);
        peek(3'd4, v); check("R5 fall flag", v, 8'h20);
        check("R5 irq", {7'd0, irq_o}, 8'h01);
    endtask

    task automatic t_change();
        logic [7:0] v;
        do_reset();
        bus_write(3'd2, 8'h04); bus_write(3'd1, 8'h04); bus_write(3'd3, 8'h04);
        pin_i[2] = 1'b1; wait_n(6);
        peek(3'd4, v); check("R6 change asserted", v, 8'h04);
        check("R6 irq", {7'd0, irq_o}, 8'h01);
        port_read(v); check("R6 port value", v, 8'h04);
        peek(3'd4, v); check("R6 read moves reference", v, 8'h00);
        pin_i[2] = 1'b0; wait_n(6);
        peek(3'd4, v); check("R6 change back asserted", v, 8'h04);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        do_reset();
        bus_write(3'd1, 8'h08);
        pin_i[3] = 1'b1; wait_n(6);
        pin_i[3] = 1'b0; wait_n(6);
        peek(3'd4, v); check("R2 disabled pin silent", v, 8'h00);
        check("R2 no irq", {7'd0, irq_o}, 8'h00);
        bus_write(3'd2, 8'h18);
        pin_i[4] = 1'b1; wait_n(6);
        peek(3'd4, v); check("R3 code 00 silent", v, 8'h00);
        check("R3 no irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_block();
        logic [7:0] v;
        do_reset();
        bus_write(3'd2, 8'h03); bus_write(3'd1, 8'h03);
        pin_i[0] = 1'b1; wait_n(6);
        check("R8 first request", {7'd0, irq_o}, 8'h01);
        ack_pulse(); wait_n(1);
        check("R10 ack clears", {7'd0, irq_o}, 8'h00);
        pin_i[1] = 1'b1; wait_n(6);
        peek(3'd4, v); check("R8 both flags", v, 8'h03);
        check("R8 blocked request", {7'd0, irq_o}, 8'h00);
        bus_write(3'd4, 8'h03); wait_n(2);
        pin_i[1] = 1'b0; wait_n(4);
        pin_i[1] = 1'b1; wait_n(6);
        check("R8 new request after clear", {7'd0, irq_o}, 8'h01);
    endtask

    task automatic t_gate();
        do_reset();
        mask_en_i = 1'b0;
        bus_write(3'd2, 8'h40); bus_write(3'd1, 8'h40);
        pin_i[6] = 1'b1; wait_n(6);
        check("R9 masked", {7'd0, irq_o}, 8'h00);
        mask_en_i = 1'b1; #1;
        check("R9 held pending shows", {7'd0, irq_o}, 8'h01);
        global_en_i = 1'b0; #1;
        check("R9 global off", {7'd0, irq_o}, 8'h00);
        global_en_i = 1'b1; #1;
        check("R9 global on", {7'd0, irq_o}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_rise();
        t_fall();
        t_change();
        t_disabled();
        t_block();
        t_gate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule